// File: doc/BRIEF.md
# Ten-Counter Core Event Monitor

This block is a bank of ten 48-bit event counters that sits beside a processor core. Software programs it through a simple synchronous register port: one write strobe, a register address, write data and a combinational read-data bus. The core feeds it four things: an active-cycle pulse, a retired-instruction pulse, an event bus carrying one pulse line per event number, and a flag giving the current privilege level.

Counter 0 always counts active cycles and counter 1 always counts retired instructions. Each of counters 2 to 9 takes an 8-bit event code and counts pulses on the event bus line with that number. A counter advances only when three conditions hold: it is enabled, the privilege filter bit for the current level is set, and no interrupt is being serviced. When an increment carries bit 47 from 0 to 1, the counter's overflow status bit is set. In fast-interrupt mode, an overflow whose interrupt enable is set raises the interrupt line. Software acknowledges by clearing the status and then the interrupt-active flag.

Register addresses are CTRL = 0, PRIV = 1, SEL0 = 2, SEL1 = 3, OVF = 4, and counter i at 16 + i. Data is CNT_W bits wide, with a minimum of 32.

Top module: `pmu_counter_bank`

## Requirements
- R1: After reset, every counter, CTRL, PRIV, SEL0, SEL1 and OVF read 0 and `irq` is low.
- R2: Counter 0 adds one for each enabled cycle with `core_active` high. Counter 1 adds one for each enabled cycle with `inst_retired` high. Nothing written to SEL0 or SEL1 changes what these two count.
- R3: Counter i (2..5) takes its code from SEL0 bits [(i-2)*8+7:(i-2)*8]. Counter i (6..9) takes its code from SEL1 bits [(i-6)*8+7:(i-6)*8]. Each counter counts cycles with `evt_bus[code]` high. A code of EVT_NUM or more never counts.
- R4: CTRL bits [7:0] enable counters 0..7 and CTRL bits [21:20] enable counters 8..9. A disabled counter holds its value.
- R5: PRIV bits [7:0] are user-level allow bits for counters 0..7 and bits [15:8] are kernel-level allow bits for 0..7. Bits [17:16] and [19:18] are the user and kernel allow bits for counters 8..9. `priv_kernel` = 1 selects the kernel bit and 0 selects the user bit.
- R6: Counters are 48 bits and wrap to 0. Status bit i of OVF is set only when an increment takes counter bit 47 from 0 to 1. Neither a wrap nor a software write sets it.
- R7: Writing OVF clears each status bit written with 1 and leaves the others. An overflow in the same cycle wins over the clear.
- R8: `irq` is high exactly when CTRL[9:8] = 2'b01 (fast mode) and some OVF bit is set whose interrupt enable is set. The interrupt enables are CTRL[19:12] for counters 0..7 and CTRL[23:22] for counters 8..9. Mode 2'b00 keeps `irq` low.
- R9: The interrupt-active flag, CTRL[11], is set on the clock edge after `irq` is high. A CTRL write loads it from bit 11 whenever `irq` is low, so writing 0 acknowledges.
- R10: While the interrupt-active flag is set, no counter increments.
- R11: A write to address 16+i loads counter i and takes priority over an increment in the same cycle. The written value reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for `reg_addr`, combinational |
| core_active | input | 1 | Active-cycle pulse for counter 0 |
| inst_retired | input | 1 | Retired-instruction pulse for counter 1 |
| evt_bus | input | EVT_NUM | One pulse line per event number |
| priv_kernel | input | 1 | 1 = kernel level, 0 = user level |
| irq | output | 1 | Fast interrupt request |

## Verification
The embedded properties check several rules on every cycle:
- each counter steps by exactly one, holds, or loads a write;
- overflow fires only on a rising bit 47;
- status bits never drop without a clear, and a fresh overflow survives a clear in the same cycle;
- the active flag follows `irq`.

Other behaviour can only be shown by the bench's scenarios. This covers decoding of event codes and privilege bits through the split bit groups, and the suppression of counting while the active flag is set. It also covers the full overflow, interrupt and acknowledge sequence, and the write-versus-increment race.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int unsigned NUM_CNT = 10;
  localparam int unsigned ADDR_W  = 5;
  localparam int unsigned CODE_W  = 8;

  localparam logic [ADDR_W-1:0] A_CTRL     = 5'd0;
  localparam logic [ADDR_W-1:0] A_PRIV     = 5'd1;
  localparam logic [ADDR_W-1:0] A_SEL0     = 5'd2;
  localparam logic [ADDR_W-1:0] A_SEL1     = 5'd3;
  localparam logic [ADDR_W-1:0] A_OVF      = 5'd4;
  localparam logic [ADDR_W-1:0] A_CNT_BASE = 5'd16;

  localparam logic [1:0] IMODE_OFF  = 2'b00;
  localparam logic [1:0] IMODE_FAST = 2'b01;
endpackage

// File: rtl/pmu_cfg_regs.sv
module pmu_cfg_regs
  import pmu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [NUM_CNT-1:0] cnt_en,
  output logic [NUM_CNT-1:0] int_en,
  output logic [NUM_CNT-1:0] usr_en,
  output logic [NUM_CNT-1:0] krn_en,
  output logic [1:0]         imode,
  output logic [31:0]        sel_lo,
  output logic [31:0]        sel_hi,
  output logic [23:0]        ctrl_view,
  output logic [19:0]        priv_view
);
  logic        ctrl_we, priv_we, sel_lo_we, sel_hi_we;
  logic [7:0]  en_lo_q, en_lo_d, ien_lo_q, ien_lo_d;
  logic [1:0]  en_hi_q, en_hi_d, ien_hi_q, ien_hi_d;
  logic [1:0]  imode_q, imode_d;
  logic [19:0] priv_q, priv_d;
  logic [31:0] sel_lo_q, sel_lo_d, sel_hi_q, sel_hi_d;

  // next-state: decode and field extraction
  always_comb begin
    ctrl_we   = reg_we && (reg_addr == A_CTRL);
    priv_we   = reg_we && (reg_addr == A_PRIV);
    sel_lo_we = reg_we && (reg_addr == A_SEL0);
    sel_hi_we = reg_we && (reg_addr == A_SEL1);
    en_lo_d   = reg_wdata[7:0];
    imode_d   = reg_wdata[9:8];
    ien_lo_d  = reg_wdata[19:12];
    en_hi_d   = reg_wdata[21:20];
    ien_hi_d  = reg_wdata[23:22];
    priv_d    = reg_wdata[19:0];
    sel_lo_d  = reg_wdata;
    sel_hi_d  = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_lo_q  <= '0;
      en_hi_q  <= '0;
      ien_lo_q <= '0;
      ien_hi_q <= '0;
      imode_q  <= IMODE_OFF;
      priv_q   <= '0;
      sel_lo_q <= '0;
      sel_hi_q <= '0;
    end else begin
      if (ctrl_we) begin
        en_lo_q  <= en_lo_d;
        en_hi_q  <= en_hi_d;
        ien_lo_q <= ien_lo_d;
        ien_hi_q <= ien_hi_d;
        imode_q  <= imode_d;
      end
      if (priv_we)   priv_q   <= priv_d;
      if (sel_lo_we) sel_lo_q <= sel_lo_d;
      if (sel_hi_we) sel_hi_q <= sel_hi_d;
    end
  end

  assign cnt_en    = {en_hi_q, en_lo_q};
  assign int_en    = {ien_hi_q, ien_lo_q};
  assign usr_en    = {priv_q[17:16], priv_q[7:0]};
  assign krn_en    = {priv_q[19:18], priv_q[15:8]};
  assign imode     = imode_q;
  assign sel_lo    = sel_lo_q;
  assign sel_hi    = sel_hi_q;
  assign ctrl_view = {ien_hi_q, en_hi_q, ien_lo_q, 2'b00, imode_q, en_lo_q};
  assign priv_view = priv_q;
endmodule

// File: rtl/pmu_event_counter.sv
module pmu_event_counter #(
  parameter int unsigned WIDTH = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_val,
  input  logic             inc,
  output logic [WIDTH-1:0] value,
  output logic             ovf_hit
);
  logic [WIDTH-1:0] cnt_q, cnt_d, cnt_inc;
  logic             ce;

  always_comb begin
    cnt_inc = cnt_q + WIDTH'(1);
    ce      = wr_en | inc;
    cnt_d   = wr_en ? wr_val : cnt_inc;
    ovf_hit = inc & ~wr_en & ~cnt_q[WIDTH-1] & cnt_inc[WIDTH-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (ce) cnt_q <= cnt_d;
  end

  assign value = cnt_q;

  p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cnt_q == $past(wr_val)));
  p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr_en) |=> (cnt_q == $past(cnt_q) + WIDTH'(1)));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !wr_en) |=> $stable(cnt_q));
  p_ovf_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_hit |=> (cnt_q[WIDTH-1] && !$past(cnt_q[WIDTH-1])));
endmodule

// File: rtl/pmu_irq_ctrl.sv
module pmu_irq_ctrl
  import pmu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CNT-1:0] ovf_set,
  input  logic               clr_we,
  input  logic [NUM_CNT-1:0] clr_mask,
  input  logic [NUM_CNT-1:0] int_en,
  input  logic [1:0]         imode,
  input  logic               ctrl_we,
  input  logic               iact_wval,
  output logic [NUM_CNT-1:0] ovf_status,
  output logic               iact,
  output logic               irq
);
  logic [NUM_CNT-1:0] ovf_q, ovf_d;
  logic               ovf_ce;
  logic               iact_q, iact_d, iact_ce;
  logic               irq_c;

  always_comb begin
    irq_c   = (imode == IMODE_FAST) && |(ovf_q & int_en);
    ovf_d   = (ovf_q & ~(clr_we ? clr_mask : '0)) | ovf_set;
    ovf_ce  = clr_we | (|ovf_set);
    iact_d  = irq_c | iact_wval;
    iact_ce = irq_c | ctrl_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q  <= '0;
      iact_q <= 1'b0;
    end else begin
      if (ovf_ce)  ovf_q  <= ovf_d;
      if (iact_ce) iact_q <= iact_d;
    end
  end

  assign ovf_status = ovf_q;
  assign iact       = iact_q;
  assign irq        = irq_c;

  p_iact_after_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> iact_q);
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> (($past(ovf_q) & ~ovf_q) == '0));
  p_ovf_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|ovf_set) |=> ((ovf_q & $past(ovf_set)) == $past(ovf_set)));
endmodule

// File: rtl/pmu_counter_bank.sv
module pmu_counter_bank
  import pmu_pkg::*;
#(
  parameter int unsigned CNT_W   = 48,
  parameter int unsigned EVT_NUM = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  input  logic              core_active,
  input  logic              inst_retired,
  input  logic [EVT_NUM-1:0] evt_bus,
  input  logic              priv_kernel,
  output logic              irq
);
  localparam int unsigned       IDX_W   = $clog2(EVT_NUM);
  localparam logic [CODE_W:0]   EVT_LIM = (CODE_W+1)'(EVT_NUM);

  logic [1:0]         rst_pipe_q;
  logic               rst_sync_n;
  logic [NUM_CNT-1:0] cnt_en, int_en, usr_en, krn_en, ovf_set, ovf_status;
  logic [1:0]         imode;
  logic [31:0]        sel_lo, sel_hi;
  logic [23:0]        ctrl_view;
  logic [19:0]        priv_view;
  logic               iact_q;
  logic               ctrl_we, clr_we;
  logic [CNT_W-1:0]   cnt_arr [NUM_CNT];

  // reset: asserted asynchronously, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign ctrl_we = reg_we && (reg_addr == A_CTRL);
  assign clr_we  = reg_we && (reg_addr == A_OVF);

  pmu_cfg_regs u_cfg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata[31:0]),
    .cnt_en    (cnt_en),
    .int_en    (int_en),
    .usr_en    (usr_en),
    .krn_en    (krn_en),
    .imode     (imode),
    .sel_lo    (sel_lo),
    .sel_hi    (sel_hi),
    .ctrl_view (ctrl_view),
    .priv_view (priv_view)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    localparam logic [ADDR_W-1:0] MY_ADDR = A_CNT_BASE + ADDR_W'(i);
    logic src, priv_ok, inc, wr;

    if (i == 0) begin : g_cycles
      assign src = core_active;
    end else if (i == 1) begin : g_insts
      assign src = inst_retired;
    end else begin : g_sel
      logic [CODE_W-1:0] code;
      if (i < 6) begin : g_lo
        assign code = sel_lo[(i-2)*CODE_W +: CODE_W];
      end else begin : g_hi
        assign code = sel_hi[(i-6)*CODE_W +: CODE_W];
      end
      assign src = ({1'b0, code} < EVT_LIM) ? evt_bus[code[IDX_W-1:0]] : 1'b0;
    end

    assign priv_ok = priv_kernel ? krn_en[i] : usr_en[i];
    assign inc     = src & cnt_en[i] & priv_ok & ~iact_q;
    assign wr      = reg_we && (reg_addr == MY_ADDR);

    pmu_event_counter #(.WIDTH(CNT_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .wr_en   (wr),
      .wr_val  (reg_wdata),
      .inc     (inc),
      .value   (cnt_arr[i]),
      .ovf_hit (ovf_set[i])
    );
  end

  pmu_irq_ctrl u_irq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ovf_set    (ovf_set),
    .clr_we     (clr_we),
    .clr_mask   (reg_wdata[NUM_CNT-1:0]),
    .int_en     (int_en),
    .imode      (imode),
    .ctrl_we    (ctrl_we),
    .iact_wval  (reg_wdata[11]),
    .ovf_status (ovf_status),
    .iact       (iact_q),
    .irq        (irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CTRL)      reg_rdata[23:0] = ctrl_view | {12'b0, iact_q, 11'b0};
    else if (reg_addr == A_PRIV) reg_rdata[19:0] = priv_view;
    else if (reg_addr == A_SEL0) reg_rdata[31:0] = sel_lo;
    else if (reg_addr == A_SEL1) reg_rdata[31:0] = sel_hi;
    else if (reg_addr == A_OVF)  reg_rdata[NUM_CNT-1:0] = ovf_status;
    for (int k = 0; k < NUM_CNT; k++) begin
      if (reg_addr == A_CNT_BASE + ADDR_W'(k)) reg_rdata = cnt_arr[k];
    end
  end

  p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (iact_q && !reg_we) |=> $stable(cnt_arr[0]) && $stable(cnt_arr[9]));
endmodule

// File: tb/pmu_counter_bank_tb.sv
module pmu_counter_bank_tb;
  localparam int CW = 48;
  localparam int EN = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [4:0]    reg_addr = '0;
  logic [CW-1:0] reg_wdata = '0;
  logic [CW-1:0] reg_rdata;
  logic          core_active = 1'b0;
  logic          inst_retired = 1'b0;
  logic [EN-1:0] evt_bus = '0;
  logic          priv_kernel = 1'b0;
  logic          irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pmu_counter_bank #(.CNT_W(CW), .EVT_NUM(EN)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_active(core_active),
    .inst_retired(inst_retired), .evt_bus(evt_bus), .priv_kernel(priv_kernel),
    .irq(irq)
  );

  // row: code[46:39] evt[38:23] kern[22] priv[21:2] exp5[1] exp8[0]
  localparam logic [46:0] VEC [8] = '{
    {8'd3,  16'h0008, 1'b0, 20'hFFFFF, 1'b1, 1'b1},
    {8'd3,  16'h0004, 1'b0, 20'hFFFFF, 1'b0, 1'b0},
    {8'd15, 16'h8000, 1'b0, 20'hFFFFF, 1'b1, 1'b1},
    {8'd16, 16'hFFFF, 1'b0, 20'hFFFFF, 1'b0, 1'b0},
    {8'd7,  16'h0080, 1'b0, 20'h10020, 1'b1, 1'b1},
    {8'd7,  16'h0080, 1'b1, 20'h10020, 1'b0, 1'b0},
    {8'd7,  16'h0080, 1'b1, 20'h42000, 1'b1, 1'b1},
    {8'd7,  16'h0080, 1'b1, 20'h02000, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [CW-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [CW-1:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic drive_evt(input logic [EN-1:0] e, input int n);
    @(negedge clk);
    evt_bus = e;
    repeat (n) @(posedge clk);
    @(negedge clk);
    evt_bus = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=100000 cycles expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(5'd0, d); check("R1 ctrl", d, 0);
    rd(5'd1, d); check("R1 priv", d, 0);
    rd(5'd2, d); check("R1 sel0", d, 0);
    rd(5'd4, d); check("R1 ovf", d, 0);
    for (int i = 0; i < 10; i++) begin
      rd(5'(16 + i), d); check("R1 counter", d, 0);
    end
    check("R1 irq", irq, 0);

    wr(5'd0, 48'h0030_00FF);

    // R3 / R5 vector table on counters 5 and 8
    for (int r = 0; r < 8; r++) begin
      logic [46:0] v;
      v = VEC[r];
      wr(5'd2, {16'h0, v[46:39], 24'h0});
      wr(5'd3, {24'h0, v[46:39], 16'h0});
      wr(5'd1, {28'h0, v[21:2]});
      wr(5'd21, 48'h0);
      wr(5'd24, 48'h0);
      priv_kernel = v[22];
      drive_evt(v[38:23], 4);
      rd(5'd21, d); check("R3/R5 counter5", d, v[1] ? 4 : 0);
      rd(5'd24, d); check("R3/R5 counter8", d, v[0] ? 4 : 0);
    end
    priv_kernel = 1'b0;
    wr(5'd1, 48'hF_FFFF);

    // R2 fixed counters ignore select codes
    wr(5'd2, 48'hFFFF_FFFF);
    wr(5'd3, 48'hFFFF_FFFF);
    wr(5'd16, 0);
    wr(5'd17, 0);
    @(negedge clk); core_active = 1'b1; inst_retired = 1'b1; evt_bus = '1;
    repeat (3) @(posedge clk);
    @(negedge clk); inst_retired = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); core_active = 1'b0; evt_bus = '0;
    rd(5'd16, d); check("R2 cycles", d, 6);
    rd(5'd17, d); check("R2 instructions", d, 3);

    // R4 enable split
    wr(5'd0, 48'h0030_00FE);
    @(negedge clk); core_active = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk); core_active = 1'b0;
    rd(5'd16, d); check("R4 counter0 disabled", d, 6);
    wr(5'd3, 48'h0100_0000);
    wr(5'd25, 0);
    wr(5'd0, 48'h0000_00FF);
    drive_evt(16'h0002, 3);
    rd(5'd25, d); check("R4 counter9 disabled", d, 0);
    wr(5'd0, 48'h0030_00FF);
    drive_evt(16'h0002, 3);
    rd(5'd25, d); check("R4 counter9 enabled", d, 3);

    // R11 write beats increment
    @(negedge clk); core_active = 1'b1; reg_we = 1'b1; reg_addr = 5'd16; reg_wdata = 48'd100;
    @(negedge clk); reg_we = 1'b0; core_active = 1'b0;
    rd(5'd16, d); check("R11 write priority", d, 100);
    wr(5'd23, 48'h1234_5678_9ABC);
    rd(5'd23, d); check("R11 readback", d, 48'h1234_5678_9ABC);

    // R6 overflow, wrap, software write
    wr(5'd2, 0);
    wr(5'd3, 0);
    wr(5'd18, 48'h7FFF_FFFF_FFFE);
    wr(5'd19, 48'hFFFF_FFFF_FFFF);
    wr(5'd20, 48'h8000_0000_0000);
    wr(5'd24, 0);
    wr(5'd0, 48'h0030_40FF);
    drive_evt(16'h0001, 1);
    rd(5'd4, d);  check("R6 no ovf on wrap or write", d, 0);
    rd(5'd19, d); check("R6 wrap", d, 0);
    drive_evt(16'h0001, 1);
    rd(5'd4, d);  check("R6 ovf bit2", d, 48'h4);
    check("R8 mode off", irq, 0);

    // R8 / R9 / R10 interrupt sequence
    wr(5'd0, 48'h0030_41FF);
    check("R8 irq fast", irq, 1);
    rd(5'd0, d); check("R9 iact set", d, 48'h0030_49FF);
    drive_evt(16'h0001, 3);
    rd(5'd18, d); check("R10 frozen", d, 48'h8000_0000_0000);
    wr(5'd4, 48'h4);
    rd(5'd4, d); check("R7 w1c", d, 0);
    check("R8 irq after clear", irq, 0);
    wr(5'd0, 48'h0030_41FF);
    rd(5'd0, d); check("R9 ack", d, 48'h0030_41FF);
    drive_evt(16'h0001, 2);
    rd(5'd18, d); check("R10 resumed", d, 48'h8000_0000_0002);

    // R7 set wins over clear
    wr(5'd18, 48'h7FFF_FFFF_FFFF);
    @(negedge clk); evt_bus = 16'h0001; reg_we = 1'b1; reg_addr = 5'd4; reg_wdata = 48'h4;
    @(negedge clk); evt_bus = '0; reg_we = 1'b0;
    rd(5'd4, d); check("R7 set wins", d, 48'h4);
    wr(5'd4, 48'h4);
    wr(5'd0, 48'h0030_40FF);
    rd(5'd0, d); check("R9 spurious ack", d, 48'h0030_40FF);

    // R8 interrupt enable split for counter 8
    wr(5'd24, 48'h7FFF_FFFF_FFFF);
    wr(5'd0, 48'h003F_F1FF);
    drive_evt(16'h0001, 1);
    rd(5'd4, d); check("R6 ovf bit8", d, 48'h100);
    check("R8 hi ien clear", irq, 0);
    wr(5'd0, 48'h00FF_F1FF);
    check("R8 hi ien set", irq, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule